// File: doc/BRIEF.md
# Region Replay Recovery Controller

This block steers the program counter so that a core can retire instructions out of order and still recover precise state when an instruction faults. It needs no reorder buffer or checkpoint. The compiler divides the program into re-executable regions. The controller keeps the start PC of the region that is running. When a fault is reported, it stores the faulting PC and sends fetch back to the region start. During the replay that follows, it lets instructions issue only up to the stored PC. When the same instruction faults again, it raises a trap that is precise at that instruction. When the handler returns, execution resumes at the faulting PC.

Two other cases are handled. If the replay produces a fault at some other PC, the region is replayed once more in a strict in-order mode, where every fault traps at once; this mode ends when the region boundary is reached. If a time-critical interrupt arrives together with the fault, the interrupt is serviced first and the replay starts after its return. Several exception lanes can report in the same cycle; the oldest report, meaning the lowest sequence number, is kept.

All inputs are one-cycle control pulses that are accepted unconditionally, so the block has no valid/ready handshake and never applies back-pressure. The redirect and trap outputs are registered one-cycle pulses. They appear in the cycle after the input event that causes them.

Top module: `region_replay_ctrl`

## Requirements
- R1: The region-start register loads `region_pc` only on a `region_adv` pulse while mode is RUN (0) or SERIAL (2), and only when no exception is reported in the same cycle. In REPLAY (1), TRAP (3) and IRQ (4) modes it keeps its value. After reset it holds `RESET_PC`.
- R2: An exception in RUN mode stores the PC of the valid lane with the lowest sequence number; on equal sequence numbers the lower lane index wins. One cycle later `redir_valid` pulses with `redir_pc` equal to the region start, and mode becomes REPLAY.
- R3: In REPLAY, `iss_allow` stays high until an issue of the stored faulting PC has been seen. From the next cycle it stays low until the mode changes. In all other modes `iss_allow` is high.
- R4: An exception in REPLAY at the stored PC pulses `trap_req` one cycle later, with `trap_pc` equal to the stored PC, and mode becomes TRAP.
- R5: `hret` in TRAP mode pulses `redir_valid` with `redir_pc` equal to the stored PC. Mode returns to RUN, or to SERIAL if the trap was raised in SERIAL mode.
- R6: An exception in REPLAY at any other PC pulses `redir_valid` to the region start and sets mode SERIAL. The stored PC is kept.
- R7: An exception in SERIAL mode pulses `trap_req` with `trap_pc` equal to the new PC, stores that PC, and sets mode TRAP.
- R8: `region_adv` in SERIAL mode, with no exception in that cycle, returns mode to RUN and loads the new region start.
- R9: An exception in RUN mode with `irq_crit` high stores the PC, gives no redirect, and sets mode IRQ. `hret` in IRQ mode then redirects to the region start and sets mode REPLAY.
- R10: Exceptions are ignored in TRAP and IRQ modes. `hret` is ignored in RUN, REPLAY and SERIAL modes.
- R11: Out of reset, mode is RUN, `redir_valid` and `trap_req` are low, and `iss_allow` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| region_adv | input | 1 | Region boundary passed the issue gate |
| region_pc | input | PCW | Start PC of the new region |
| exc_valid | input | NEXC | Exception report valid, one bit per lane |
| exc_pc | input | NEXC*PCW | Faulting PC per lane, lane 0 in the low bits |
| exc_seq | input | NEXC*SEQW | Program-order sequence number per lane |
| irq_crit | input | 1 | Time-critical interrupt pending |
| hret | input | 1 | Handler return |
| iss_valid | input | 1 | An instruction issues this cycle |
| iss_pc | input | PCW | PC of the issuing instruction |
| iss_allow | output | 1 | Issue permitted (issue limit) |
| redir_valid | output | 1 | Fetch redirect pulse |
| redir_pc | output | PCW | Redirect target |
| trap_req | output | 1 | Precise trap request pulse |
| trap_pc | output | PCW | PC at which the trap is precise |
| mode | output | 3 | 0 RUN, 1 REPLAY, 2 SERIAL, 3 TRAP, 4 IRQ |

## Verification
The bench builds the block with PCW=16, SEQW=4 and NEXC=3. Three lanes make it possible to test a three-way pick with a tie on sequence number, where the lane with the lower index must win. The 16-bit PCs keep the expected values short. The sequence covers:
- a region boundary that arrives in the same cycle as a fault;
- a boundary that arrives during replay;
- faults in TRAP mode, which must be ignored;
- an escalation to SERIAL mode, followed by a trap taken inside it and the return to SERIAL;
- the interrupt-first path.

// File: rtl/rrc_pkg.sv
package rrc_pkg;
  typedef enum logic [2:0] {
    MODE_RUN    = 3'd0,
    MODE_REPLAY = 3'd1,
    MODE_SERIAL = 3'd2,
    MODE_TRAP   = 3'd3,
    MODE_IRQ    = 3'd4
  } rrc_mode_e;
endpackage

// File: rtl/rrc_pick.sv
// Oldest-report selector: lowest sequence number, lower lane on ties.
module rrc_pick #(
  parameter int NEXC = 2,
  parameter int PCW  = 32,
  parameter int SEQW = 6
) (
  input  logic [NEXC-1:0]      valid,
  input  logic [NEXC*PCW-1:0]  pc_flat,
  input  logic [NEXC*SEQW-1:0] seq_flat,
  output logic                 any,
  output logic [PCW-1:0]       sel_pc
);
  logic [PCW-1:0]  lane_pc  [NEXC];
  logic [SEQW-1:0] lane_seq [NEXC];
  logic [NEXC-1:0] grant;

  for (genvar g = 0; g < NEXC; g++) begin : g_lane
    assign lane_pc[g]  = pc_flat[g*PCW +: PCW];
    assign lane_seq[g] = seq_flat[g*SEQW +: SEQW];
  end

  always_comb begin
    logic [SEQW-1:0] best;
    best   = '1;
    grant  = '0;
    sel_pc = '0;
    for (int i = 0; i < NEXC; i++) begin
      if (valid[i] && (grant == '0 || lane_seq[i] < best)) begin
        grant    = '0;
        grant[i] = 1'b1;
        best     = lane_seq[i];
        sel_pc   = lane_pc[i];
      end
    end
    assert_one_grant_R2: assert ($onehot0(grant));
  end

  assign any = |valid;
endmodule

// File: rtl/rrc_issue_gate.sv
// Replay issue limiter: passes issue up to and including the stored PC.
module rrc_issue_gate #(
  parameter int PCW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           clear,
  input  logic           active,
  input  logic           iss_valid,
  input  logic [PCW-1:0] iss_pc,
  input  logic [PCW-1:0] limit_pc,
  output logic           allow
);
  logic reached;
  logic hit;

  assign hit = active && iss_valid && (iss_pc == limit_pc);

  always_ff @(posedge clk) begin
    if (!rst_n)     reached <= 1'b0;
    else if (clear) reached <= 1'b0;
    else if (hit)   reached <= 1'b1;
  end

  assign allow = !(active && reached);

  assert_hold_after_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(hit) && !$past(clear) && active) |-> !allow);
  assert_free_outside_replay_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !active |-> allow);
endmodule

// File: rtl/region_replay_ctrl.sv
module region_replay_ctrl
  import rrc_pkg::*;
#(
  parameter int PCW  = 32,
  parameter int SEQW = 6,
  parameter int NEXC = 2,
  parameter logic [PCW-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 region_adv,
  input  logic [PCW-1:0]       region_pc,
  input  logic [NEXC-1:0]      exc_valid,
  input  logic [NEXC*PCW-1:0]  exc_pc,
  input  logic [NEXC*SEQW-1:0] exc_seq,
  input  logic                 irq_crit,
  input  logic                 hret,
  input  logic                 iss_valid,
  input  logic [PCW-1:0]       iss_pc,
  output logic                 iss_allow,
  output logic                 redir_valid,
  output logic [PCW-1:0]       redir_pc,
  output logic                 trap_req,
  output logic [PCW-1:0]       trap_pc,
  output logic [2:0]           mode
);
  rrc_mode_e      mode_q;
  logic [PCW-1:0] region_start;
  logic [PCW-1:0] fault_pc;
  logic           from_serial;
  logic           exc_any;
  logic [PCW-1:0] exc_sel_pc;
  logic           enter_replay;

  rrc_pick #(.NEXC(NEXC), .PCW(PCW), .SEQW(SEQW)) u_pick (
    .valid(exc_valid), .pc_flat(exc_pc), .seq_flat(exc_seq),
    .any(exc_any), .sel_pc(exc_sel_pc)
  );

  assign enter_replay = (mode_q == MODE_RUN && exc_any && !irq_crit) ||
                        (mode_q == MODE_IRQ && hret);

  rrc_issue_gate #(.PCW(PCW)) u_gate (
    .clk(clk), .rst_n(rst_n), .clear(enter_replay),
    .active(mode_q == MODE_REPLAY), .iss_valid(iss_valid),
    .iss_pc(iss_pc), .limit_pc(fault_pc), .allow(iss_allow)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_RUN;
      region_start <= RESET_PC;
      fault_pc     <= '0;
      from_serial  <= 1'b0;
      redir_valid  <= 1'b0;
      redir_pc     <= '0;
      trap_req     <= 1'b0;
      trap_pc      <= '0;
    end else begin
      redir_valid <= 1'b0;
      trap_req    <= 1'b0;
      unique case (mode_q)
        MODE_RUN: begin
          if (exc_any) begin
            fault_pc <= exc_sel_pc;
            if (irq_crit) begin
              mode_q <= MODE_IRQ;
            end else begin
              redir_valid <= 1'b1;
              redir_pc    <= region_start;
              mode_q      <= MODE_REPLAY;
            end
          end else if (region_adv) begin
            region_start <= region_pc;
          end
        end
        MODE_REPLAY: begin
          if (exc_any) begin
            if (exc_sel_pc == fault_pc) begin
              trap_req    <= 1'b1;
              trap_pc     <= fault_pc;
              from_serial <= 1'b0;
              mode_q      <= MODE_TRAP;
            end else begin
              redir_valid <= 1'b1;
              redir_pc    <= region_start;
              mode_q      <= MODE_SERIAL;
            end
          end
        end
        MODE_SERIAL: begin
          if (exc_any) begin
            fault_pc    <= exc_sel_pc;
            trap_req    <= 1'b1;
            trap_pc     <= exc_sel_pc;
            from_serial <= 1'b1;
            mode_q      <= MODE_TRAP;
          end else if (region_adv) begin
            region_start <= region_pc;
            mode_q       <= MODE_RUN;
          end
        end
        MODE_TRAP: begin
          if (hret) begin
            redir_valid <= 1'b1;
            redir_pc    <= fault_pc;
            mode_q      <= from_serial ? MODE_SERIAL : MODE_RUN;
          end
        end
        MODE_IRQ: begin
          if (hret) begin
            redir_valid <= 1'b1;
            redir_pc    <= region_start;
            mode_q      <= MODE_REPLAY;
          end
        end
        default: mode_q <= MODE_RUN;
      endcase
    end
  end

  assign mode = mode_q;

  assert_trap_enters_handler_R4: assert property (@(posedge clk) disable iff (!rst_n)
    trap_req |-> mode_q == MODE_TRAP);
  assert_redir_trap_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(redir_valid && trap_req));
  assert_start_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(region_adv) |-> $stable(region_start));
  assert_return_pc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_q) == MODE_TRAP && $past(hret)) |-> (redir_valid && redir_pc == $past(fault_pc)));
  assert_irq_no_redirect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_IRQ && $past(mode_q) == MODE_RUN) |-> !redir_valid);
endmodule

// File: tb/region_replay_ctrl_tb.sv
module region_replay_ctrl_tb;
  localparam int PCW = 16, SEQW = 4, NEXC = 3;

  logic clk = 0, rst_n = 0;
  logic region_adv = 0;
  logic [PCW-1:0] region_pc = '0;
  logic [NEXC-1:0] exc_valid = '0;
  logic [NEXC*PCW-1:0] exc_pc = '0;
  logic [NEXC*SEQW-1:0] exc_seq = '0;
  logic irq_crit = 0, hret = 0, iss_valid = 0;
  logic [PCW-1:0] iss_pc = '0;
  logic iss_allow, redir_valid, trap_req;
  logic [PCW-1:0] redir_pc, trap_pc;
  logic [2:0] mode;

  always #2 clk = ~clk;

  region_replay_ctrl #(.PCW(PCW), .SEQW(SEQW), .NEXC(NEXC)) u_dut (
    .clk(clk), .rst_n(rst_n), .region_adv(region_adv), .region_pc(region_pc),
    .exc_valid(exc_valid), .exc_pc(exc_pc), .exc_seq(exc_seq),
    .irq_crit(irq_crit), .hret(hret), .iss_valid(iss_valid), .iss_pc(iss_pc),
    .iss_allow(iss_allow), .redir_valid(redir_valid), .redir_pc(redir_pc),
    .trap_req(trap_req), .trap_pc(trap_pc), .mode(mode)
  );

  int tests = 0, fails = 0, cycles = 0;
  string cur_req = "R11";

  // behavioural reference model
  int m_state = 0, m_start = 0, m_fault = 0, m_reached = 0, m_ser = 0;
  int m_redir = 0, m_rpc = 0, m_trap = 0, m_tpc = 0;

  always @(posedge clk) begin
    int any, best, sel;
    if (!rst_n) begin
      m_state = 0; m_start = 0; m_fault = 0; m_reached = 0; m_ser = 0;
      m_redir = 0; m_rpc = 0; m_trap = 0; m_tpc = 0;
    end else begin
      any = 0; best = 0; sel = 0;
      for (int i = 0; i < NEXC; i++)
        if (exc_valid[i] && (!any || int'(exc_seq[i*SEQW +: SEQW]) < best)) begin
          any = 1; best = int'(exc_seq[i*SEQW +: SEQW]); sel = int'(exc_pc[i*PCW +: PCW]);
        end
      m_redir = 0; m_trap = 0;
      case (m_state)
        0: if (any) begin
             m_fault = sel;
             if (irq_crit) m_state = 4;
             else begin m_redir = 1; m_rpc = m_start; m_state = 1; m_reached = 0; end
           end else if (region_adv) m_start = int'(region_pc);
        1: begin
             if (iss_valid && int'(iss_pc) == m_fault) m_reached = 1;
             if (any) begin
               if (sel == m_fault) begin m_trap = 1; m_tpc = m_fault; m_ser = 0; m_state = 3; end
               else begin m_redir = 1; m_rpc = m_start; m_state = 2; end
             end
           end
        2: if (any) begin
             m_fault = sel; m_trap = 1; m_tpc = sel; m_ser = 1; m_state = 3;
           end else if (region_adv) begin m_start = int'(region_pc); m_state = 0; end
        3: if (hret) begin m_redir = 1; m_rpc = m_fault; m_state = m_ser ? 2 : 0; end
        4: if (hret) begin m_redir = 1; m_rpc = m_start; m_state = 1; m_reached = 0; end
        default: m_state = 0;
      endcase
    end
  end

  task automatic chk(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", cur_req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("mode", int'(mode), m_state);
      chk("redir_valid", int'(redir_valid), m_redir);
      if (m_redir != 0) chk("redir_pc", int'(redir_pc), m_rpc);
      chk("trap_req", int'(trap_req), m_trap);
      if (m_trap != 0) chk("trap_pc", int'(trap_pc), m_tpc);
      chk("iss_allow", int'(iss_allow), (m_state == 1 && m_reached != 0) ? 0 : 1);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      fails++; tests++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic idle();
    @(negedge clk);
    region_adv = 0; exc_valid = '0; irq_crit = 0; hret = 0; iss_valid = 0;
  endtask

  task automatic adv(int pc);
    region_adv = 1; region_pc = PCW'(pc); idle();
  endtask

  task automatic exc1(int pc);
    exc_valid = 3'b001; exc_pc[0 +: PCW] = PCW'(pc); exc_seq[0 +: SEQW] = 4'd1; idle();
  endtask

  task automatic issue(int pc);
    iss_valid = 1; iss_pc = PCW'(pc); idle();
  endtask

  task automatic ret();
    hret = 1; idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    cur_req = "R11";
    tests++;
    if (mode !== 3'd0 || redir_valid !== 1'b0 || trap_req !== 1'b0 || iss_allow !== 1'b1) begin
      fails++;
      $display("FAIL R11 reset: actual mode %0d redir %0b trap %0b allow %0b expected 0 0 0 1",
               mode, redir_valid, trap_req, iss_allow);
    end
    idle();
    cur_req = "R1"; adv('h100); ret(); idle();
    // R2: three lanes, tie on seq between lanes 1 and 2 -> lane 1
    cur_req = "R2";
    exc_valid = 3'b111;
    exc_pc  = {16'h0118, 16'h0110, 16'h0120};
    exc_seq = {4'd3, 4'd3, 4'd5};
    region_adv = 1; region_pc = 16'h0200;
    idle(); idle();
    cur_req = "R3";
    issue('h100); issue('h104); adv('h500); issue('h110); issue('h114); issue('h118); idle();
    cur_req = "R4"; exc1('h110); idle();
    cur_req = "R10"; exc1('h120); idle();
    cur_req = "R5"; ret(); idle();
    cur_req = "R10"; ret(); idle();
    cur_req = "R6"; adv('h300); exc1('h308); issue('h300); exc1('h304); issue('h30c); idle();
    cur_req = "R7"; exc1('h30c); idle();
    cur_req = "R5"; ret(); idle();
    cur_req = "R8"; adv('h400); idle();
    cur_req = "R9"; irq_crit = 1; exc1('h410); exc1('h414); idle();
    ret(); issue('h400); issue('h410); issue('h414); idle();
    cur_req = "R4"; exc1('h410); ret(); idle();
    cur_req = "R1"; adv('h600); exc1('h604); idle();
    repeat (3) idle();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule